// File: doc/BRIEF.md
# Set-Associative Tag Lookup with Exact LRU Replacement

This block is the tag side of a set-associative cache. A lookup request carries a set index and a tag. The block compares the tag against every way of the selected set at the same time. One cycle later it reports whether a valid way matched, which way matched, and which way should be replaced if the access missed. Data arrays, write policy and the path to backing memory belong to other blocks.

Replacement follows exact least-recently-used order. Each set keeps a complete ranking of its ways from least to most recently touched. A hit or a fill moves the touched way to the most-recent end of that ranking. Empty ways are always used before any way that holds a valid tag. A separate fill command installs a new tag into the replacement way of a chosen set, and the new contents are visible to a lookup issued in the next cycle.

The way count and the set count are parameters. With one way the block behaves as a direct-mapped tag store. With one set it behaves as a fully associative one. The default is 4 ways by 8 sets, and a 3-way by 8-set build is also supported.

Top module: `setassoc_lru_tags`

## Requirements
- R1: A lookup consults only the set named by `req_set`, and a tag may reside in any way of that set; a tag installed in one set does not hit in another set.
- R2: A lookup hits when a valid way of the selected set holds `req_tag`. `rsp_way` then gives that way as a binary number, and if several ways match it gives the lowest-numbered one. On a miss `rsp_hit` is 0 and `rsp_way` is 0.
- R3: Every lookup produces exactly one response, and it comes one cycle later: `rsp_valid` in a cycle equals `req_valid` of the previous cycle, and back-to-back requests give back-to-back responses.
- R4: `rsp_victim` is the way to replace in the looked-up set. It is the lowest-numbered invalid way if any way is invalid. Otherwise it is the way whose last hit or fill lies furthest in the past.
- R5: A hit makes the hitting way the most recently used of its set, and the other ways of that set keep their relative order.
- R6: A fill writes `fill_tag` into the replacement way of `fill_set`, as R4 defines it, and marks that way valid and most recently used. The change is made at the clock edge where `fill_valid` is sampled, so a lookup of that tag and set in the next cycle hits.
- R7: A lookup in the same cycle as a fill sees the contents from before that fill. If both target the same set, only the fill updates that set's recency order. If they target different sets, both updates are applied.
- R8: While reset is held, `rsp_valid` is 0. After reset every way is invalid, and each set's order runs from way 0 as least recent up to the last way as most recent.
- R9: With a single way the block acts as a direct-mapped store: the replacement way is always 0 and each fill replaces the previous tag of the set.
- R10: With a single set the block acts as a fully associative store: the set inputs are ignored and every tag competes for the same ways.
- R11: A 3-way build works. `rsp_way` and `rsp_victim` never name a way number at or above the way count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_set | input | SET_W | Set index of the lookup |
| req_tag | input | TAG_W | Tag of the lookup |
| fill_valid | input | 1 | Fill command strobe |
| fill_set | input | SET_W | Set that receives the fill |
| fill_tag | input | TAG_W | Tag to install |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Lookup matched a valid way |
| rsp_way | output | WAY_W | Way that matched, 0 on a miss |
| rsp_victim | output | WAY_W | Way to replace in the looked-up set |

## Verification
The bench drives four builds from one stimulus: 4x8, 3x8, direct-mapped 1x8 and fully associative 4x1. It goes after the ordering corners. These are filling an empty set, where a design that ignored validity would evict a live way. They also include a hit followed by a fill, where a recency list that was not promoted would evict the line just used. On a 3-way set the bench checks that the replacement way never lands on the missing fourth way. It also checks a lookup and a fill to the same set in one cycle. A design that let the lookup see the new tag would report a false hit, and one that applied the hit promotion after the fill would corrupt the order. A long pseudo-random stream over a small tag range builds up duplicate fills and mixed hits. If the recency update were wrong, it would show up as a wrong replacement way many accesses later.

// File: rtl/sal_pkg.sv
// Package: shared helpers for the set-associative tag lookup.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package sal_pkg;

    // Width of an index able to address n items; never below one bit.
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sal_tag_store.sv
// Module: sal_tag_store
// Holds a tag and a valid bit for every way of every set. It compares the
// lookup tag against all ways of the lookup set in parallel. It also exposes
// the valid bits of the fill set and writes one way per cycle on a fill.
// Assumes SETS is a power of two (or 1) and that the caller keeps every set
// and way index in range.
module sal_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int TAG_W = 8,
    localparam int WAY_W = sal_pkg::idx_bits(WAYS),
    localparam int SET_W = sal_pkg::idx_bits(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [WAYS-1:0]  lk_hits,
    output logic [WAYS-1:0]  lk_valid,
    input  logic [SET_W-1:0] fl_set,
    output logic [WAYS-1:0]  fl_valid,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [WAYS-1:0]  valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];

    // Valid bits: cleared by reset, set when a way is filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
            end
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    // Tag storage: written on fill, needs no reset because valid guards it.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
        end
    end

    assign lk_valid = valid_q[lk_set];
    assign fl_valid = valid_q[fl_set];

    // One comparator per way, all evaluated in the same cycle.
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign lk_hits[g] = valid_q[lk_set][g] && (tag_q[lk_set][g] == lk_tag);
    end

endmodule

// File: rtl/sal_recency.sv
// Module: sal_recency
// Keeps one complete recency ranking per set. Position 0 holds the least
// recently used way and position WAYS-1 the most recent. A promotion moves
// one way to the top and slides the entries above its old slot down by one.
// When a fill and a hit name the same set in one cycle, only the fill applies.
// Assumes the promoted way numbers are below WAYS.
module sal_recency #(
    parameter int WAYS = 4,
    parameter int SETS = 8,
    localparam int WAY_W = sal_pkg::idx_bits(WAYS),
    localparam int SET_W = sal_pkg::idx_bits(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic             hit_en,
    input  logic [WAY_W-1:0] hit_way,
    input  logic [SET_W-1:0] fl_set,
    input  logic             fill_en,
    input  logic [WAY_W-1:0] fill_way,
    output logic [WAY_W-1:0] lk_lru,
    output logic [WAY_W-1:0] fl_lru
);

    typedef logic [WAYS-1:0][WAY_W-1:0] order_t;

    order_t order_q [SETS];
    order_t hit_next;
    order_t fill_next;

    // Returns the ranking with way w moved to the most-recent slot.
    function automatic order_t promote(input order_t cur, input logic [WAY_W-1:0] w);
        order_t nxt;
        logic   passed;
        passed = 1'b0;
        for (int p = 0; p < WAYS - 1; p++) begin
            if (cur[p] == w) passed = 1'b1;
            nxt[p] = passed ? cur[p+1] : cur[p];
        end
        nxt[WAYS-1] = w;
        return nxt;
    endfunction

    // Candidate rankings for the two sets that may change this cycle.
    always_comb begin
        hit_next  = promote(order_q[lk_set], hit_way);
        fill_next = promote(order_q[fl_set], fill_way);
    end

    // Ranking registers: reset to way order, fill wins over hit per set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int p = 0; p < WAYS; p++) begin
                    order_q[s][p] <= WAY_W'(p);
                end
            end
        end else begin
            for (int s = 0; s < SETS; s++) begin
                if (fill_en && (fl_set == SET_W'(s))) begin
                    order_q[s] <= fill_next;
                end else if (hit_en && (lk_set == SET_W'(s))) begin
                    order_q[s] <= hit_next;
                end
            end
        end
    end

    assign lk_lru = order_q[lk_set][0];
    assign fl_lru = order_q[fl_set][0];

endmodule

// File: rtl/sal_victim.sv
// Module: sal_victim
// Chooses the way to replace in one set. It takes the lowest-numbered invalid
// way when one exists and the least recently used way otherwise.
// Assumes lru_way is below WAYS.
module sal_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = sal_pkg::idx_bits(WAYS)
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAY_W-1:0] lru_way,
    output logic [WAY_W-1:0] victim
);

    // Descending scan so the lowest invalid way is the last one written.
    always_comb begin
        victim = lru_way;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) victim = WAY_W'(i);
        end
    end

endmodule

// File: rtl/setassoc_lru_tags.sv
// Module: setassoc_lru_tags (top)
// Tag-side lookup for an N-way set-associative cache with exact LRU
// replacement. A lookup compares all ways of one set and registers hit, way
// and replacement way for one cycle. A fill writes the replacement way of its
// set at the edge where it is sampled. A lookup in the same cycle sees the
// contents from before the fill. Assumes SETS is a power of two; with
// SETS == 1 the set inputs are ignored.
module setassoc_lru_tags #(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int TAG_W = 8,
    localparam int WAY_W = sal_pkg::idx_bits(WAYS),
    localparam int SET_W = sal_pkg::idx_bits(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SET_W-1:0] req_set,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             fill_valid,
    input  logic [SET_W-1:0] fill_set,
    input  logic [TAG_W-1:0] fill_tag,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [WAY_W-1:0] rsp_way,
    output logic [WAY_W-1:0] rsp_victim
);

    localparam bit ONE_SET = (SETS == 1);

    logic [SET_W-1:0] lk_set_e;
    logic [SET_W-1:0] fl_set_e;
    logic [WAYS-1:0]  lk_hits;
    logic [WAYS-1:0]  lk_valid;
    logic [WAYS-1:0]  fl_valid;
    logic [WAY_W-1:0] lk_lru;
    logic [WAY_W-1:0] fl_lru;
    logic [WAY_W-1:0] lk_victim;
    logic [WAY_W-1:0] fl_victim;
    logic [WAY_W-1:0] hit_way;
    logic             any_hit;

    // A single set ignores the index inputs entirely.
    assign lk_set_e = ONE_SET ? '0 : req_set;
    assign fl_set_e = ONE_SET ? '0 : fill_set;

    sal_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_set   (lk_set_e),
        .lk_tag   (req_tag),
        .lk_hits  (lk_hits),
        .lk_valid (lk_valid),
        .fl_set   (fl_set_e),
        .fl_valid (fl_valid),
        .wr_en    (fill_valid),
        .wr_set   (fl_set_e),
        .wr_way   (fl_victim),
        .wr_tag   (fill_tag)
    );

    sal_recency #(.WAYS(WAYS), .SETS(SETS)) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_set   (lk_set_e),
        .hit_en   (req_valid && any_hit),
        .hit_way  (hit_way),
        .fl_set   (fl_set_e),
        .fill_en  (fill_valid),
        .fill_way (fl_victim),
        .lk_lru   (lk_lru),
        .fl_lru   (fl_lru)
    );

    sal_victim #(.WAYS(WAYS)) u_lk_victim (
        .valid   (lk_valid),
        .lru_way (lk_lru),
        .victim  (lk_victim)
    );

    sal_victim #(.WAYS(WAYS)) u_fl_victim (
        .valid   (fl_valid),
        .lru_way (fl_lru),
        .victim  (fl_victim)
    );

    // Encode the match vector; the lowest matching way wins.
    always_comb begin
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (lk_hits[i]) hit_way = WAY_W'(i);
        end
    end

    assign any_hit = |lk_hits;

    // Response register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_way    <= '0;
            rsp_victim <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_hit    <= req_valid && any_hit;
            rsp_way    <= any_hit ? hit_way : '0;
            rsp_victim <= lk_victim;
        end
    end

endmodule

// File: rtl/sal_lookup_chk.sv
// Module: sal_lookup_chk
// Port-level checker for setassoc_lru_tags, attached with bind below.
// Assumes the same parameters as the checked instance.
module sal_lookup_chk #(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int TAG_W = 8,
    localparam int WAY_W = sal_pkg::idx_bits(WAYS),
    localparam int SET_W = sal_pkg::idx_bits(SETS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [SET_W-1:0] req_set,
    input logic [TAG_W-1:0] req_tag,
    input logic             fill_valid,
    input logic [SET_W-1:0] fill_set,
    input logic [TAG_W-1:0] fill_tag,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [WAY_W-1:0] rsp_way,
    input logic [WAY_W-1:0] rsp_victim
);

    // R3
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R2
    miss_way_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_way == '0));

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid);

    // R6
    fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_valid) && req_valid &&
         (req_set == $past(fill_set)) && (req_tag == $past(fill_tag)))
        |=> rsp_hit);

    if ((1 << WAY_W) != WAYS) begin : g_range
        // R11
        way_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid |-> (int'(rsp_way) < WAYS));

        // R11
        victim_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid |-> (int'(rsp_victim) < WAYS));
    end

endmodule

bind setassoc_lru_tags sal_lookup_chk #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_set    (req_set),
    .req_tag    (req_tag),
    .fill_valid (fill_valid),
    .fill_set   (fill_set),
    .fill_tag   (fill_tag),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_way    (rsp_way),
    .rsp_victim (rsp_victim)
);

// File: tb/setassoc_lru_tags_test.sv
// Scoreboard bench: four builds (4x8, 3x8, 1x8, 4x1) share one stimulus.
// The driver predicts results with a timestamp model and queues them; the
// monitor compares them after each clock edge.
module setassoc_lru_tags_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCFG = 4;
    localparam int NW [NCFG] = '{4, 3, 1, 4};
    localparam int NS [NCFG] = '{8, 8, 8, 1};

    typedef struct packed {
        logic [3:0]      hit;
        logic [3:0][1:0] way;
        logic [3:0][1:0] vic;
        logic [3:0]      ph;
    } exp_t;

    string PH [7] = '{"R8 reset", "R4 empty set", "R6 fill", "R5 promote",
                      "R1 set select", "R7 same cycle", "R3 stream"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_set = '0;
    logic [7:0] req_tag = '0;
    logic fill_valid = 1'b0;
    logic [2:0] fill_set = '0;
    logic [7:0] fill_tag = '0;

    logic [3:0] o_v, o_h;
    logic [1:0] o_w [NCFG];
    logic [1:0] o_x [NCFG];
    logic       dm_w, dm_x;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;
    int phase = 0;

    int  mtag   [NCFG][8][4];
    bit  mval   [NCFG][8][4];
    int  mstamp [NCFG][8][4];
    int  stamp_ctr = 0;
    exp_t sb [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    setassoc_lru_tags #(.WAYS(4), .SETS(8), .TAG_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
        .req_tag(req_tag), .fill_valid(fill_valid), .fill_set(fill_set),
        .fill_tag(fill_tag), .rsp_valid(o_v[0]), .rsp_hit(o_h[0]),
        .rsp_way(o_w[0]), .rsp_victim(o_x[0]));

    setassoc_lru_tags #(.WAYS(3), .SETS(8), .TAG_W(8)) uut_w3 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
        .req_tag(req_tag), .fill_valid(fill_valid), .fill_set(fill_set),
        .fill_tag(fill_tag), .rsp_valid(o_v[1]), .rsp_hit(o_h[1]),
        .rsp_way(o_w[1]), .rsp_victim(o_x[1]));

    setassoc_lru_tags #(.WAYS(1), .SETS(8), .TAG_W(8)) uut_dm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set),
        .req_tag(req_tag), .fill_valid(fill_valid), .fill_set(fill_set),
        .fill_tag(fill_tag), .rsp_valid(o_v[2]), .rsp_hit(o_h[2]),
        .rsp_way(dm_w), .rsp_victim(dm_x));

    setassoc_lru_tags #(.WAYS(4), .SETS(1), .TAG_W(8)) uut_fa (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_set(req_set[0]),
        .req_tag(req_tag), .fill_valid(fill_valid), .fill_set(fill_set[0]),
        .fill_tag(fill_tag), .rsp_valid(o_v[3]), .rsp_hit(o_h[3]),
        .rsp_way(o_w[3]), .rsp_victim(o_x[3]));

    assign o_w[2] = {1'b0, dm_w};
    assign o_x[2] = {1'b0, dm_x};

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_set(input int c, input int s);
        return (NS[c] == 1) ? 0 : s;
    endfunction

    function automatic int m_victim(input int c, input int s);
        int best;
        for (int w = 0; w < NW[c]; w++) if (!mval[c][s][w]) return w;
        best = 0;
        for (int w = 1; w < NW[c]; w++) if (mstamp[c][s][w] < mstamp[c][s][best]) best = w;
        return best;
    endfunction

    function automatic int m_hitway(input int c, input int s, input int t);
        for (int w = 0; w < NW[c]; w++) if (mval[c][s][w] && mtag[c][s][w] == t) return w;
        return -1;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCFG; c++)
            for (int s = 0; s < 8; s++)
                for (int w = 0; w < 4; w++) begin
                    mval[c][s][w]   = 1'b0;
                    mtag[c][s][w]   = 0;
                    mstamp[c][s][w] = w - 100;
                end
    endtask

    // One cycle of stimulus; prediction uses the state from before the edge.
    task automatic step(input bit rv, input int rs, input int rt,
                        input bit fv, input int fs, input int ft);
        exp_t e;
        int   hw [NCFG];
        int   fvw [NCFG];
        @(negedge clk);
        req_valid  = rv;
        req_set    = 3'(rs);
        req_tag    = 8'(rt);
        fill_valid = fv;
        fill_set   = 3'(fs);
        fill_tag   = 8'(ft);
        e = '0;
        e.ph = 4'(phase);
        for (int c = 0; c < NCFG; c++) begin
            hw[c]  = m_hitway(c, eff_set(c, rs), rt);
            fvw[c] = m_victim(c, eff_set(c, fs));
            e.hit[c] = (hw[c] >= 0);
            e.way[c] = (hw[c] >= 0) ? 2'(hw[c]) : 2'd0;
            e.vic[c] = 2'(m_victim(c, eff_set(c, rs)));
        end
        for (int c = 0; c < NCFG; c++) begin
            stamp_ctr++;
            if (fv) begin
                mval[c][eff_set(c, fs)][fvw[c]]   = 1'b1;
                mtag[c][eff_set(c, fs)][fvw[c]]   = ft;
                mstamp[c][eff_set(c, fs)][fvw[c]] = stamp_ctr;
            end
            if (rv && hw[c] >= 0 && !(fv && eff_set(c, fs) == eff_set(c, rs)))
                mstamp[c][eff_set(c, rs)][hw[c]] = stamp_ctr;
        end
        if (rv) sb.push_back(e);
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 1'b0, 0, 0);
    endtask

    // Monitor: after each edge check strobe timing and pop the expectations.
    initial begin
        forever begin
            exp_t e;
            string vr;
            @(posedge clk);
            #1;
            if (done) break;
            for (int c = 0; c < NCFG; c++)
                chk(rst_n ? "R3" : "R8", $sformatf("rsp_valid cfg%0d", c),
                    int'(o_v[c]), (rst_n && req_valid) ? 1 : 0);
            if (o_v[0]) begin
                if (sb.size() == 0) begin
                    chk("R3", "unexpected response", 1, 0);
                end else begin
                    e = sb.pop_front();
                    for (int c = 0; c < NCFG; c++) begin
                        vr = (c == 1) ? "R11" : (c == 2) ? "R9" : (c == 3) ? "R10" : "R4";
                        chk({"R2 ", PH[e.ph]}, $sformatf("hit cfg%0d", c), int'(o_h[c]), int'(e.hit[c]));
                        chk({"R2 ", PH[e.ph]}, $sformatf("way cfg%0d", c), int'(o_w[c]), int'(e.way[c]));
                        chk({vr, " ", PH[e.ph]}, $sformatf("victim cfg%0d", c), int'(o_x[c]), int'(e.vic[c]));
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL R3 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        model_reset();
        phase = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4: empty sets miss and offer way 0.
        phase = 1;
        step(1'b1, 2, 8'h11, 1'b0, 0, 0);
        step(1'b1, 5, 8'h22, 1'b0, 0, 0);

        // R6: fill four tags into set 2, then look each up.
        phase = 2;
        step(1'b0, 0, 0, 1'b1, 2, 8'h11);
        step(1'b1, 2, 8'h11, 1'b1, 2, 8'h22);
        step(1'b0, 0, 0, 1'b1, 2, 8'h33);
        step(1'b0, 0, 0, 1'b1, 2, 8'h44);
        step(1'b1, 2, 8'h11, 1'b0, 0, 0);
        step(1'b1, 2, 8'h22, 1'b0, 0, 0);
        step(1'b1, 2, 8'h33, 1'b0, 0, 0);
        step(1'b1, 2, 8'h44, 1'b0, 0, 0);

        // R5: promote by hits, then fills must evict the oldest way.
        phase = 3;
        step(1'b1, 2, 8'h22, 1'b0, 0, 0);
        step(1'b1, 2, 8'h99, 1'b1, 2, 8'h55);
        step(1'b1, 2, 8'h77, 1'b1, 2, 8'h66);
        for (int t = 1; t <= 7; t++) step(1'b1, 2, t * 8'h11, 1'b0, 0, 0);

        // R1: a tag lives only in its own set (except the one-set build).
        phase = 4;
        step(1'b0, 0, 0, 1'b1, 3, 8'h11);
        step(1'b1, 3, 8'h11, 1'b0, 0, 0);
        step(1'b1, 4, 8'h11, 1'b0, 0, 0);
        step(1'b1, 6, 8'h66, 1'b0, 0, 0);

        // R7: lookup and fill in the same cycle, same set and other set.
        phase = 5;
        step(1'b1, 2, 8'hA0, 1'b1, 2, 8'hA0);
        step(1'b1, 2, 8'hA0, 1'b0, 0, 0);
        step(1'b1, 2, 8'h66, 1'b1, 2, 8'hB0);
        step(1'b1, 2, 8'hB0, 1'b0, 0, 0);
        step(1'b1, 3, 8'h11, 1'b1, 2, 8'hC0);
        step(1'b1, 2, 8'hC0, 1'b1, 3, 8'hD0);
        for (int t = 0; t < 4; t++) step(1'b1, 3, (t == 0) ? 8'h11 : 8'hD0, 1'b0, 0, 0);

        // R3: back-to-back pseudo-random traffic over a small tag range.
        phase = 6;
        for (int n = 0; n < 600; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[1:0] != 2'b00, int'(lf[4:3]), int'(lf[7:5]) % 6,
                 lf[9:8] == 2'b00, int'(lf[11:10]), int'(lf[14:12]) % 6);
        end
        repeat (4) idle();
        @(negedge clk);
        chk("R3", "responses left pending", sb.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
        $finish;
    end

endmodule